// File: doc/BRIEF.md
# Two-Dice Craps Game Controller

This block plays a game of craps driven by one roll request line. While the request is held high, two dice counters step once per clock through all 36 combinations. The moment the request is released decides the roll, which makes the result hard to predict. One clock after the release, a control state machine adds the two dice and judges the roll.

On the opening roll the player wins on 7 or 11 and loses on 2, 3 or 12. Any other sum becomes the point, and the game waits for more rolls. On each later roll, a sum equal to the point wins, a 7 loses, and anything else calls for another roll. A finished game shows its win or lose flag until reset. The roll request must already be debounced. Display driving happens outside the block.

Top module: `craps_game`

## Requirements
- R1: Each die shows a value from 1 to 6. The pair steps in the order (1,1),(1,2)..(1,6),(2,1)..(6,6) and then back to (1,1). The second die advances fastest, and the first die steps when the second wraps from 6 to 1.
- R2: The dice advance one step on each rising clock edge at which roll_req is high and the game is not over. At all other edges they hold their value.
- R3: A roll is judged at the first rising edge at which roll_req is low after having been high. Its outcome shows on win, lose and point right after that edge.
- R4: On the opening roll, a sum of 7 or 11 sets win.
- R5: On the opening roll, a sum of 2, 3 or 12 sets lose.
- R6: Any other opening sum is loaded into point, and both win and lose stay low.
- R7: Later rolls never reload point.
- R8: On a later roll, a sum equal to point sets win.
- R9: On a later roll, a sum of 7 sets lose. Any other sum, including 11, 2, 3 and 12, leaves both flags low and waits for another roll.
- R10: Win and lose are never high together. Once set, a flag stays high until reset, and roll requests no longer move the dice.
- R11: Reset is synchronous and active low on rst_n. While it is applied, the dice become (1,1), point becomes 0, and win and lose go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| roll_req | input | 1 | Debounced roll button, high while held |
| die_a | output | 3 | First die, 1 to 6 |
| die_b | output | 3 | Second die, 1 to 6 |
| point | output | 4 | Stored point, 0 until set |
| win | output | 1 | Game won, held until reset |
| lose | output | 1 | Game lost, held until reset |

## Verification
The bench raises roll_req at a falling edge and holds it for N rising edges, which advances the dice by exactly N steps. It drops the request at the next falling edge. The judging edge is the rising edge after that drop, so the dice, point and flags are sampled at the falling edge half a cycle later. This is the first moment their new values are due. An index model in the bench, modulo 36, predicts the dice, and the expected outcome is worked out from the craps rules on that predicted pair.

// File: rtl/craps_pkg.sv
// Shared definitions for the craps game controller.
package craps_pkg;
    typedef enum logic [2:0] {
        ST_FIRST = 3'd0,
        ST_WAIT  = 3'd1,
        ST_LATER = 3'd2,
        ST_WIN   = 3'd3,
        ST_LOSE  = 3'd4
    } game_state_t;
endpackage

// File: rtl/dice_counter.sv
// Two chained dice counters. The second die counts fastest and the
// first die steps when the second wraps from the top face back to 1.
// Assumes: en comes from the controller; synchronous active-low reset.
module dice_counter #(
    parameter int FACES = 6,
    localparam int DW = $clog2(FACES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [DW-1:0] die_a,
    output logic [DW-1:0] die_b
);
    localparam logic [DW-1:0] ONE = DW'(1);
    localparam logic [DW-1:0] TOP = DW'(FACES);

    // Advance the 36-state pair while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            die_a <= ONE;
            die_b <= ONE;
        end else if (en) begin
            if (die_b == TOP) begin
                die_b <= ONE;
                die_a <= (die_a == TOP) ? ONE : die_a + ONE;
            end else begin
                die_b <= die_b + ONE;
            end
        end
    end

    // R1
    die_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (die_a >= ONE && die_a <= TOP && die_b >= ONE && die_b <= TOP));
    // R2
    die_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(rst_n)) |=> ($stable(die_a) && $stable(die_b)));
endmodule

// File: rtl/sum_decoder.sv
// Adds the dice and decodes the conditions the controller needs.
// Purely combinational.
module sum_decoder #(
    parameter int DW = 3,
    parameter int SW = 4
) (
    input  logic [DW-1:0] die_a,
    input  logic [DW-1:0] die_b,
    input  logic [SW-1:0] point,
    output logic          is_seven,
    output logic          is_natural,
    output logic          is_craps,
    output logic          is_point
);
    logic [SW-1:0] total;

    // Sum and compare against the fixed craps values and the stored point.
    always_comb begin
        total      = SW'(die_a) + SW'(die_b);
        is_seven   = (total == SW'(7));
        is_natural = (total == SW'(7)) || (total == SW'(11));
        is_craps   = (total == SW'(2)) || (total == SW'(3)) || (total == SW'(12));
        is_point   = (total == point);
    end
endmodule

// File: rtl/point_reg.sv
// Holds the point. Loads only on the store strobe from the controller.
// Assumes: store fires at most once per game; synchronous active-low reset.
module point_reg #(
    parameter int DW = 3,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          store,
    input  logic [DW-1:0] die_a,
    input  logic [DW-1:0] die_b,
    output logic [SW-1:0] point
);
    // Capture the current sum on store.
    always_ff @(posedge clk) begin
        if (!rst_n)     point <= '0;
        else if (store) point <= SW'(die_a) + SW'(die_b);
    end

    // R7
    point_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!store && $past(rst_n)) |=> $stable(point));
endmodule

// File: rtl/craps_fsm.sv
// Game controller. A roll is judged on the edge after roll_req falls.
// Assumes: roll_req is debounced and synchronous; synchronous active-low reset.
module craps_fsm
    import craps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic roll_req,
    input  logic is_seven,
    input  logic is_natural,
    input  logic is_craps,
    input  logic is_point,
    output logic roll_en,
    output logic store_pt,
    output logic win,
    output logic lose
);
    game_state_t state, nxt;
    logic        req_d;
    logic        release_evt;

    // Remember last request level for release detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_d <= 1'b0;
        else        req_d <= roll_req;
    end

    assign release_evt = req_d && !roll_req;

    // Next state and strobes.
    always_comb begin
        nxt      = state;
        store_pt = 1'b0;
        roll_en  = 1'b0;
        unique case (state)
            ST_FIRST: begin
                roll_en = roll_req;
                if (release_evt) begin
                    if (is_natural)    nxt = ST_WIN;
                    else if (is_craps) nxt = ST_LOSE;
                    else begin
                        store_pt = 1'b1;
                        nxt      = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                roll_en = roll_req;
                if (roll_req) nxt = ST_LATER;
            end
            ST_LATER: begin
                roll_en = roll_req;
                if (release_evt) begin
                    if (is_point)      nxt = ST_WIN;
                    else if (is_seven) nxt = ST_LOSE;
                    else               nxt = ST_WAIT;
                end
            end
            ST_WIN:  nxt = ST_WIN;
            ST_LOSE: nxt = ST_LOSE;
            default: nxt = ST_FIRST;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FIRST;
        else        state <= nxt;
    end

    assign win  = (state == ST_WIN);
    assign lose = (state == ST_LOSE);

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(win && lose));
    // R10
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win |=> win);
    // R10
    lose_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lose |=> lose);
    // R2
    over_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win || lose) |-> !roll_en);
    // R3
    store_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_pt |-> (release_evt && !roll_en));
endmodule

// File: rtl/craps_game.sv
// Top level of the craps game: dice counters, point register,
// sum decoder and controller. All logic on the rising edge of clk.
module craps_game #(
    parameter int FACES = 6,
    localparam int DW = $clog2(FACES + 1),
    localparam int SW = $clog2(2 * FACES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          roll_req,
    output logic [DW-1:0] die_a,
    output logic [DW-1:0] die_b,
    output logic [SW-1:0] point,
    output logic          win,
    output logic          lose
);
    logic roll_en, store_pt;
    logic is_seven, is_natural, is_craps, is_point;

    dice_counter #(.FACES(FACES)) u_dice (
        .clk(clk), .rst_n(rst_n), .en(roll_en),
        .die_a(die_a), .die_b(die_b));

    sum_decoder #(.DW(DW), .SW(SW)) u_dec (
        .die_a(die_a), .die_b(die_b), .point(point),
        .is_seven(is_seven), .is_natural(is_natural),
        .is_craps(is_craps), .is_point(is_point));

    point_reg #(.DW(DW), .SW(SW)) u_point (
        .clk(clk), .rst_n(rst_n), .store(store_pt),
        .die_a(die_a), .die_b(die_b), .point(point));

    craps_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .roll_req(roll_req),
        .is_seven(is_seven), .is_natural(is_natural),
        .is_craps(is_craps), .is_point(is_point),
        .roll_en(roll_en), .store_pt(store_pt),
        .win(win), .lose(lose));
endmodule

// File: tb/tb_craps_game.sv
module tb_craps_game;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       roll_req = 1'b0;
    logic [2:0] die_a, die_b;
    logic [3:0] point;
    logic       win, lose;

    int checks = 0;
    int errors = 0;
    int idx = 0;    // model: position in the 36-state sequence
    bit done = 1'b0;

    craps_game dut (.clk(clk), .rst_n(rst_n), .roll_req(roll_req),
        .die_a(die_a), .die_b(die_b), .point(point), .win(win), .lose(lose));

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; roll_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; idx = 0;
    endtask

    // Hold request for n rising edges, release, sample after the judging edge.
    task automatic roll(input int n, input bit moves);
        @(negedge clk); roll_req = 1'b1;
        repeat (n) @(negedge clk);
        roll_req = 1'b0;
        @(negedge clk);
        if (moves) idx = (idx + n) % 36;
        chk("R1 die_a", int'(die_a), idx / 6 + 1);
        chk("R1 die_b", int'(die_b), idx % 6 + 1);
    endtask

    task automatic expect_out(input string req, input int p, input bit w, input bit l);
        chk({req, " point"}, int'(point), p);
        chk({req, " win"}, int'(win), int'(w));
        chk({req, " lose"}, int'(lose), int'(l));
    endtask

    task automatic t_reset();   // R11
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 die_a", int'(die_a), 1);
        chk("R11 die_b", int'(die_b), 1);
        expect_out("R11", 0, 1'b0, 1'b0);
        rst_n = 1'b1; idx = 0;
    endtask

    task automatic t_first_seven();   // R4: (1,6)
        do_reset(); roll(5, 1'b1); expect_out("R4 seven", 0, 1'b1, 1'b0);
    endtask

    task automatic t_first_eleven_and_hold();   // R4, R10
        do_reset(); roll(29, 1'b1); expect_out("R4 eleven", 0, 1'b1, 1'b0);
        roll(4, 1'b0);   // dice frozen, flag held
        expect_out("R10 held", 0, 1'b1, 1'b0);
    endtask

    task automatic t_first_craps();   // R5: 3, 12, 2
        do_reset(); roll(1, 1'b1);  expect_out("R5 three", 0, 1'b0, 1'b1);
        roll(3, 1'b0); expect_out("R10 lose held", 0, 1'b0, 1'b1);
        do_reset(); roll(35, 1'b1); expect_out("R5 twelve", 0, 1'b0, 1'b1);
        do_reset(); roll(36, 1'b1); expect_out("R5 two", 0, 1'b0, 1'b1);
    endtask

    task automatic t_point_win();   // R6, R7, R8, R9, R3
        do_reset(); roll(2, 1'b1); expect_out("R6 point four", 4, 1'b0, 1'b0);
        roll(2, 1'b1);  expect_out("R7 six keeps point", 4, 1'b0, 1'b0);   // (1,5)
        roll(25, 1'b1); expect_out("R9 eleven continues", 4, 1'b0, 1'b0); // (5,6)
        roll(7, 1'b1);  expect_out("R9 two continues", 4, 1'b0, 1'b0);    // (1,1)
        roll(1, 1'b1);  expect_out("R9 three continues", 4, 1'b0, 1'b0);  // (1,2)
        roll(6, 1'b1);  expect_out("R8 point hit", 4, 1'b1, 1'b0);        // (2,2)
    endtask

    task automatic t_point_lose();   // R9
        do_reset(); roll(4, 1'b1); expect_out("R6 point six", 6, 1'b0, 1'b0); // (1,5)
        roll(6, 1'b1); expect_out("R9 seven loses", 6, 1'b0, 1'b1);          // (2,5)
    endtask

    task automatic t_idle_hold();   // R2: no request, no motion
        do_reset(); roll(3, 1'b1);
        repeat (5) @(negedge clk);
        chk("R2 idle die_a", int'(die_a), idx / 6 + 1);
        chk("R2 idle die_b", int'(die_b), idx % 6 + 1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_first_seven();
        t_first_eleven_and_hold();
        t_first_craps();
        t_point_win();
        t_point_lose();
        t_idle_hold();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule